// File: doc/BRIEF.md
# Code Memory Lock Guard

This block sits between an 8-bit controller core and its code memories. It decides which code-memory accesses are allowed. The inputs are three non-volatile lock bits and an external-access strap pin. From the lock bits it derives a protection level from 0 to 3, and that level removes one privilege after another: programming, cross-boundary table reads, verify reads, and finally execution from external memory.

The strap pin chooses between internal and external execution. Once the first lock bit is programmed, the block stops using the live pin level. It uses a copy captured during reset instead, and it raises a flag whenever the captured copy disagrees with the pin.

For each request (instruction fetch, table read, program, verify) the block returns a registered grant one clock after the request. It also returns a routing bit for fetches. Internal code space covers the low 4 KB. Anything above that boundary, or anything fetched while the effective strap is low, goes to external memory.

Top module: `code_lock_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every grant output, `fetch_ext` and `tbl_data` become 0 after that edge, and `strap_latched` takes the value of `strap_pin`.
- R2: `prot_level` counts the consecutive programmed lock bits starting at `lock_bits[0]` (1 = programmed). The result is 0 when bit 0 is clear, 1 for bit 0 only, 2 for bits 0 and 1, and 3 for all three. A programmed bit after a clear bit is ignored.
- R3: After reset is released, `strap_latched` holds its value whatever `strap_pin` does. The effective strap is the live `strap_pin` at level 0 and `strap_latched` at any level above 0.
- R4: `fetch_ext` is 1 when the effective strap is 0 or when `fetch_addr` is 0x1000 or above. Otherwise it is 0.
- R5: A fetch request is granted unless it routes to external memory at level 3.
- R6: A table read is refused when the level is 1 or more, `tbl_from_ext` is 1 and the target is internal. The target is internal when the effective strap is 1 and the address is below 0x1000. A refused read returns `tbl_data` = 0x00.
- R7: A granted table read with an internal target returns `tbl_rdata_int` on `tbl_data`. Any other granted read, and any cycle with no table-read request, returns 0x00.
- R8: A program request is granted only at level 0.
- R9: A verify request is granted only at levels 0 and 1.
- R10: `strap_mismatch` is 1 exactly when the level is 1 or more and `strap_latched` differs from `strap_pin`. It is combinational.
- R11: Grants, `fetch_ext` and `tbl_data` are registered, valid one clock edge after the request. A grant is never given without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_bits | input | 3 | Lock bits, 1 = programmed, bit 0 first |
| strap_pin | input | 1 | External-access strap, 1 = internal execution |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | Fetch address |
| tbl_req | input | 1 | Table-read request |
| tbl_addr | input | 16 | Table-read address |
| tbl_from_ext | input | 1 | Table-read instruction runs from external memory |
| tbl_rdata_int | input | 8 | Internal code memory data at tbl_addr |
| prog_req | input | 1 | Programming request |
| verify_req | input | 1 | Verify request |
| fetch_grant | output | 1 | Fetch granted |
| fetch_ext | output | 1 | Fetch routed to external memory |
| tbl_grant | output | 1 | Table read granted |
| tbl_data | output | 8 | Table-read data from internal memory, or 0x00 |
| prog_grant | output | 1 | Programming granted |
| verify_grant | output | 1 | Verify granted |
| strap_latched | output | 1 | Strap value captured during reset |
| strap_mismatch | output | 1 | Captured strap differs from live pin |
| prot_level | output | 2 | Protection level 0..3 |

## Verification
`prot_level`, `strap_mismatch` and `strap_latched` are due in the same cycle as the inputs they depend on. Every grant, `fetch_ext` and `tbl_data` are due one rising edge after the request. The bench drives all inputs on the falling edge, lets exactly one rising edge pass, and samples every output at the next falling edge. This lines up the one-edge registered results and the combinational flags without racing either edge. The captured strap is set by a full reset with a chosen pin level. The pin is then moved, and the bench checks that the captured value stays put.

// File: rtl/code_lock_pkg.sv
// Package: shared constants for the code memory lock guard.
// Assumes an 8-bit data path and a 16-bit code address space.
package code_lock_pkg;
    localparam int CL_ADDR_W    = 16;
    localparam int CL_DATA_W    = 8;
    localparam int CL_NUM_LOCK  = 3;
    localparam int CL_INT_BYTES = 4096;
    localparam int CL_LVL_W     = $clog2(CL_NUM_LOCK + 1);
endpackage

// File: rtl/code_lock_level.sv
// Module: code_lock_level
// Turns the lock bits into a protection level: the number of consecutive
// programmed bits starting at bit 0. Assumes 1 = programmed. Purely combinational.
module code_lock_level #(
    parameter int NUM_LOCK = 3,
    parameter int LVL_W    = $clog2(NUM_LOCK + 1)
) (
    input  logic [NUM_LOCK-1:0] lock_bits,
    output logic [LVL_W-1:0]    level
);
    logic [NUM_LOCK-1:0] chain;

    // Build the prefix-AND chain so a bit counts only if all earlier bits do.
    genvar g;
    generate
        for (g = 0; g < NUM_LOCK; g++) begin : g_chain
            if (g == 0) begin : g_first
                assign chain[g] = lock_bits[g];
            end else begin : g_rest
                assign chain[g] = chain[g-1] & lock_bits[g];
            end
        end
    endgenerate

    // Count the surviving links of the chain.
    always_comb begin
        level = '0;
        for (int i = 0; i < NUM_LOCK; i++) begin
            level = level + LVL_W'(chain[i]);
        end
    end
endmodule

// File: rtl/code_lock_strap.sv
// Module: code_lock_strap
// Captures the strap pin on every clock edge while reset is held, and holds
// it once reset is released. Picks the live pin or the captured value as the
// effective strap, and flags a disagreement. Before the first reset the
// captured value is undefined.
module code_lock_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_pin,
    input  logic locked,
    output logic strap_latched,
    output logic strap_eff,
    output logic mismatch
);
    // Sample the pin during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_latched <= strap_pin;
        end
    end

    // Choose the strap source and compare it with the pin.
    always_comb begin
        strap_eff = locked ? strap_latched : strap_pin;
        mismatch  = locked && (strap_latched != strap_pin);
    end
endmodule

// File: rtl/code_lock_gate.sv
// Module: code_lock_gate
// Decides grants and routing for each request from the level and the
// effective strap, and registers the results. Assumes internal code space
// starts at address 0 and spans INT_BYTES.
module code_lock_gate #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int NUM_LOCK  = 3,
    parameter int LVL_W     = $clog2(NUM_LOCK + 1),
    parameter int INT_BYTES = 4096,
    parameter int VFY_LEVEL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level,
    input  logic              strap_eff,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              tbl_req,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              tbl_from_ext,
    input  logic [DATA_W-1:0] tbl_rdata_int,
    input  logic              prog_req,
    input  logic              verify_req,
    output logic              fetch_grant,
    output logic              fetch_ext,
    output logic              tbl_grant,
    output logic [DATA_W-1:0] tbl_data,
    output logic              prog_grant,
    output logic              verify_grant
);
    localparam logic [ADDR_W:0]  INT_LIMIT = INT_BYTES[ADDR_W:0];
    localparam logic [LVL_W-1:0] LVL_EXT   = LVL_W'(NUM_LOCK);
    localparam logic [LVL_W-1:0] LVL_VFY   = LVL_W'(VFY_LEVEL);

    logic              f_ext_d, f_ok_d, t_int_d, t_ok_d, p_ok_d, v_ok_d;
    logic [DATA_W-1:0] t_data_d;
    logic              any_lock;

    // Compute next-cycle grants and routing.
    always_comb begin
        any_lock = (level != '0);
        f_ext_d  = !strap_eff || ({1'b0, fetch_addr} >= INT_LIMIT);
        f_ok_d   = fetch_req && !(f_ext_d && (level == LVL_EXT));
        t_int_d  = strap_eff && ({1'b0, tbl_addr} < INT_LIMIT);
        t_ok_d   = tbl_req && !(any_lock && tbl_from_ext && t_int_d);
        t_data_d = (t_ok_d && t_int_d) ? tbl_rdata_int : '0;
        p_ok_d   = prog_req && !any_lock;
        v_ok_d   = verify_req && (level < LVL_VFY);
    end

    // Register all results; clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_grant  <= 1'b0;
            fetch_ext    <= 1'b0;
            tbl_grant    <= 1'b0;
            tbl_data     <= '0;
            prog_grant   <= 1'b0;
            verify_grant <= 1'b0;
        end else begin
            fetch_grant  <= f_ok_d;
            fetch_ext    <= f_ext_d;
            tbl_grant    <= t_ok_d;
            tbl_data     <= t_data_d;
            prog_grant   <= p_ok_d;
            verify_grant <= v_ok_d;
        end
    end
endmodule

// File: rtl/code_lock_guard.sv
// Module: code_lock_guard (top)
// Access guard for code memory: derives the protection level, manages the
// strap capture, and grants or refuses fetch, table-read, program and verify
// requests. Assumes lock bits are stable while the core runs.
module code_lock_guard
    import code_lock_pkg::*;
#(
    parameter int ADDR_W    = CL_ADDR_W,
    parameter int DATA_W    = CL_DATA_W,
    parameter int NUM_LOCK  = CL_NUM_LOCK,
    parameter int INT_BYTES = CL_INT_BYTES,
    parameter int LVL_W     = $clog2(NUM_LOCK + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LOCK-1:0] lock_bits,
    input  logic                strap_pin,
    input  logic                fetch_req,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                tbl_req,
    input  logic [ADDR_W-1:0]   tbl_addr,
    input  logic                tbl_from_ext,
    input  logic [DATA_W-1:0]   tbl_rdata_int,
    input  logic                prog_req,
    input  logic                verify_req,
    output logic                fetch_grant,
    output logic                fetch_ext,
    output logic                tbl_grant,
    output logic [DATA_W-1:0]   tbl_data,
    output logic                prog_grant,
    output logic                verify_grant,
    output logic                strap_latched,
    output logic                strap_mismatch,
    output logic [LVL_W-1:0]    prot_level
);
    logic strap_eff;

    code_lock_level #(.NUM_LOCK(NUM_LOCK), .LVL_W(LVL_W)) i_level (
        .lock_bits (lock_bits),
        .level     (prot_level)
    );

    code_lock_strap i_strap (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_pin     (strap_pin),
        .locked        (prot_level != '0),
        .strap_latched (strap_latched),
        .strap_eff     (strap_eff),
        .mismatch      (strap_mismatch)
    );

    code_lock_gate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCK(NUM_LOCK),
        .LVL_W(LVL_W), .INT_BYTES(INT_BYTES), .VFY_LEVEL(2)
    ) i_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .level         (prot_level),
        .strap_eff     (strap_eff),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .tbl_req       (tbl_req),
        .tbl_addr      (tbl_addr),
        .tbl_from_ext  (tbl_from_ext),
        .tbl_rdata_int (tbl_rdata_int),
        .prog_req      (prog_req),
        .verify_req    (verify_req),
        .fetch_grant   (fetch_grant),
        .fetch_ext     (fetch_ext),
        .tbl_grant     (tbl_grant),
        .tbl_data      (tbl_data),
        .prog_grant    (prog_grant),
        .verify_grant  (verify_grant)
    );
endmodule

// File: rtl/code_lock_guard_chk.sv
// Module: code_lock_guard_chk
// Checker bound to code_lock_guard; watches port behaviour over time.
module code_lock_guard_chk #(
    parameter int NUM_LOCK = 3,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_LOCK-1:0] lock_bits,
    input logic                prog_req,
    input logic                fetch_req,
    input logic                fetch_grant,
    input logic                fetch_ext,
    input logic                tbl_grant,
    input logic [DATA_W-1:0]   tbl_data,
    input logic                prog_grant,
    input logic                verify_grant,
    input logic                strap_latched
);
    // R8
    prog_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_grant |-> ($past(prog_req) && !$past(lock_bits[0])));

    // R9
    verify_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_grant |-> !$past(lock_bits[0] && lock_bits[1]));

    // R5
    ext_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_grant && fetch_ext) |-> !$past(&lock_bits));

    // R6
    deny_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_grant |-> (tbl_data == '0));

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_latched));

    // R11
    fetch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> $past(fetch_req));
endmodule

bind code_lock_guard code_lock_guard_chk #(.NUM_LOCK(NUM_LOCK), .DATA_W(DATA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lock_bits     (lock_bits),
    .prog_req      (prog_req),
    .fetch_req     (fetch_req),
    .fetch_grant   (fetch_grant),
    .fetch_ext     (fetch_ext),
    .tbl_grant     (tbl_grant),
    .tbl_data      (tbl_data),
    .prog_grant    (prog_grant),
    .verify_grant  (verify_grant),
    .strap_latched (strap_latched)
);

// File: tb/test_code_lock_guard.sv
// Bench: sweeps lock bits, captured strap, live pin, addresses and table-read
// origin; expected values computed arithmetically from the requirements.
module test_code_lock_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  lock_bits;
    logic        strap_pin;
    logic        fetch_req, tbl_req, tbl_from_ext, prog_req, verify_req;
    logic [15:0] fetch_addr, tbl_addr;
    logic [7:0]  tbl_rdata_int;
    logic        fetch_grant, fetch_ext, tbl_grant, prog_grant, verify_grant;
    logic [7:0]  tbl_data;
    logic        strap_latched, strap_mismatch;
    logic [1:0]  prot_level;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    code_lock_guard i_code_lock_guard (
        .clk(clk), .rst_n(rst_n), .lock_bits(lock_bits), .strap_pin(strap_pin),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .tbl_req(tbl_req),
        .tbl_addr(tbl_addr), .tbl_from_ext(tbl_from_ext),
        .tbl_rdata_int(tbl_rdata_int), .prog_req(prog_req),
        .verify_req(verify_req), .fetch_grant(fetch_grant),
        .fetch_ext(fetch_ext), .tbl_grant(tbl_grant), .tbl_data(tbl_data),
        .prog_grant(prog_grant), .verify_grant(verify_grant),
        .strap_latched(strap_latched), .strap_mismatch(strap_mismatch),
        .prot_level(prot_level)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_req = 0; tbl_req = 0; prog_req = 0; verify_req = 0;
        tbl_from_ext = 0; fetch_addr = '0; tbl_addr = '0; tbl_rdata_int = '0;
    endtask

    // Reset with a given pin level, release, leave at a falling edge.
    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 0; strap_pin = pin; idle_inputs();
        @(negedge clk);
        @(negedge clk);
        // R1: outputs cleared, strap captured
        chk("R1 fetch_grant", fetch_grant, 0);
        chk("R1 tbl_data", tbl_data, 0);
        chk("R1 prog_grant", prog_grant, 0);
        chk("R1 strap_latched", strap_latched, pin);
        rst_n = 1;
    endtask

    initial begin
        rst_n = 0; lock_bits = '0; strap_pin = 0; idle_inputs();
        for (int lb = 0; lb < 8; lb++) begin
            for (int s = 0; s < 2; s++) begin
                lock_bits = 3'(lb);
                do_reset(s[0]);
                for (int p = 0; p < 2; p++) begin
                    for (int ai = 0; ai < 4; ai++) begin
                        for (int fx = 0; fx < 2; fx++) begin
                            for (int rq = 0; rq < 2; rq++) begin
                                logic [15:0] a;
                                int lvl, eff, ext, tint, tok, tdat;
                                a = (ai == 0) ? 16'h0000 : (ai == 1) ? 16'h0FFF :
                                    (ai == 2) ? 16'h1000 : 16'hFFFF;
                                // drive on falling edge
                                strap_pin = p[0];
                                fetch_req = rq[0]; tbl_req = rq[0];
                                prog_req = rq[0]; verify_req = rq[0];
                                fetch_addr = a; tbl_addr = a; tbl_from_ext = fx[0];
                                tbl_rdata_int = a[7:0] ^ 8'h5A ^ 8'(ai);
                                // expected values from the requirements
                                lvl = (lb[0] == 0) ? 0 : (lb[1] == 0) ? 1 : (lb[2] == 0) ? 2 : 3;
                                eff = (lvl == 0) ? p : s;
                                ext = (eff == 0 || a >= 16'h1000) ? 1 : 0;
                                tint = (eff == 1 && a < 16'h1000) ? 1 : 0;
                                tok = (rq == 1 && !(lvl >= 1 && fx == 1 && tint == 1)) ? 1 : 0;
                                tdat = (tok == 1 && tint == 1) ? int'(tbl_rdata_int) : 0;
                                // R2 and R10 are combinational: same cycle
                                #1;
                                chk("R2 prot_level", prot_level, lvl);
                                chk("R10 strap_mismatch", strap_mismatch,
                                    (lvl >= 1 && s != p) ? 1 : 0);
                                @(negedge clk);
                                // R3 captured strap holds after release
                                chk("R3 strap_latched", strap_latched, s);
                                chk("R4 fetch_ext", fetch_ext, ext);
                                chk("R5 fetch_grant", fetch_grant,
                                    (rq == 1 && !(ext == 1 && lvl == 3)) ? 1 : 0);
                                chk("R6 tbl_grant", tbl_grant, tok);
                                chk("R7 tbl_data", tbl_data, tdat);
                                chk("R8 prog_grant", prog_grant, (rq == 1 && lvl == 0) ? 1 : 0);
                                chk("R9 verify_grant", verify_grant, (rq == 1 && lvl < 2) ? 1 : 0);
                                // R11: no request gives no grant
                                if (rq == 0) chk("R11 any_grant",
                                    fetch_grant | tbl_grant | prog_grant | verify_grant, 0);
                            end
                        end
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule